// File: doc/BRIEF.md
# USB Device Endpoint Control Unit

This block holds the software-visible control state of a four-endpoint USB device and turns that state into a handshake decision each time the token side reports a transaction. A word-wide CPU bus reads and writes a small register file. It holds one control word per endpoint, the number of the latest start-of-frame, the device address assigned during enumeration, and a write-only completion register that the control endpoint's firmware uses to report the outcome of a request.

When the token side presents an endpoint number and a direction, the block answers one cycle later with one of five replies: ignore (no handshake), NAK, STALL, send a zero-length packet, or proceed with data. The reply depends only on that endpoint's control bits. Hardware clears the Arm bit when the packet engine reports that a transfer has completed. It clears the Stall bit after one STALL has been issued, so firmware re-arms each transfer explicitly. Endpoint 0 is the default control pipe. Endpoints 1 to 3 can run interrupt, bulk or isochronous traffic. Serial coding, CRC, buffering and descriptor handling are done elsewhere.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset, every endpoint word, the address register and the frame register read as zero, and hsValid is low.
- R2: The word addresses are: 0 frame number (read-only, writes have no effect), 1 device address, 2 command-done (reads as zero), and 4 to 7 the control words of endpoints 0 to 3. An endpoint word keeps bits 5:0 (bit0 Enable, bit1 Arm, bit2 Stall, bit3 Dir, bit4 Iso, bit5 ZeroLen), and bits 15:6 read as zero.
- R3: A token presented with tokValid in one cycle is answered in the next cycle with hsValid high, hsEp equal to the token's endpoint, and hsCode encoded as 0 ignore, 1 NAK, 2 STALL, 3 zero-length, 4 proceed. hsValid is low in every other cycle.
- R4: A token to an endpoint whose Enable bit is 0 gets code 0 (ignore), whatever the endpoint's other bits are.
- R5: A non-isochronous enabled endpoint with matching direction, Stall 0 and Arm 0 replies with code 1 (NAK).
- R6: On a non-isochronous enabled endpoint with matching direction, Stall 1 wins over Arm and gives code 2. Hardware then clears the Stall bit, so the next token gets the Arm-based reply.
- R7: An armed, enabled, non-stalled endpoint with matching direction replies with code 4, or with code 3 when ZeroLen is 1. A doneValid pulse for an endpoint clears its Arm bit.
- R8: A token whose direction (tokIn 1 = IN) differs from the endpoint's Dir bit (1 = IN) gets code 0 and changes neither Arm nor Stall.
- R9: An isochronous endpoint never replies NAK or STALL and never clears its Stall bit. When armed it gives code 4, or code 3 with ZeroLen. When unarmed it gives code 0.
- R10: A sofValid pulse latches the 11-bit sofFrame into the frame register, which reads back in bits 10:0 with bits 15:11 zero.
- R11: The address register stores bits 6:0 of a write, reads back with bits 15:7 zero, and drives devAddr.
- R12: A write to the command-done register raises cmdDoneValid for exactly the next cycle, with cmdDoneErr equal to bit 0 of the written word (0 success, 1 error).
- R13: When a CPU write to an endpoint word and a hardware clear of the same word fall in the same cycle, the written value is kept in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | CPU bus access strobe |
| busWr | input | 1 | CPU bus write (1) or read (0) |
| busAddr | input | 4 | CPU word address |
| busWdata | input | 16 | CPU write data |
| busRdata | output | 16 | CPU read data, combinational on busAddr |
| sofValid | input | 1 | Start-of-frame received |
| sofFrame | input | 11 | Frame number of that start-of-frame |
| tokValid | input | 1 | Token presented |
| tokEp | input | 2 | Token endpoint number |
| tokIn | input | 1 | Token direction, 1 = IN |
| doneValid | input | 1 | Transfer completed |
| doneEp | input | 2 | Endpoint whose transfer completed |
| hsValid | output | 1 | Handshake decision valid |
| hsCode | output | 3 | Handshake decision code |
| hsEp | output | 2 | Endpoint the decision belongs to |
| devAddr | output | 7 | Current device address |
| cmdDoneValid | output | 1 | Command-done write pulse |
| cmdDoneErr | output | 1 | Command-done status, 1 = error |

## Verification
The bench targets the priority ladder. It uses endpoints that are stalled and armed together, isochronous endpoints with Stall set, disabled endpoints with Arm and Dir set, and tokens in the wrong direction to armed endpoints. A design with the ladder misordered would answer NAK or proceed where STALL is due, would stall an isochronous pipe, or would let a wrong-direction token through. Follow-up tokens and read-backs check that Stall is cleared after exactly one STALL and that Arm survives a mismatched token. A design that cleared the wrong bit, or never cleared it, would give a second STALL or a lost transfer. A write and a completion to the same endpoint in the same cycle check that the write is not lost to the hardware clear. Read-backs of the reserved bits in each register check that they read as zero.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
  localparam int NUM_EP    = 4;
  localparam int EP_IDX_W  = $clog2(NUM_EP);
  localparam int WORD_W    = 16;
  localparam int FRAME_W   = 11;
  localparam int DEVADDR_W = 7;
  localparam int BUS_AW    = 4;
  localparam int CTRL_W    = 6;

  // control word bit positions
  localparam int B_EN   = 0;
  localparam int B_ARM  = 1;
  localparam int B_STL  = 2;
  localparam int B_DIR  = 3;
  localparam int B_ISO  = 4;
  localparam int B_ZLP  = 5;

  // word addresses
  localparam int A_FRAME   = 0;
  localparam int A_DEVADDR = 1;
  localparam int A_CMD     = 2;
  localparam int A_EP_BASE = 4;

  typedef logic [CTRL_W-1:0] ctrl_t;

  typedef enum logic [2:0] {
    HS_IGNORE  = 3'd0,
    HS_NAK     = 3'd1,
    HS_STALL   = 3'd2,
    HS_ZLP     = 3'd3,
    HS_PROCEED = 3'd4
  } hs_e;

  // control -> datapath clear requests, one bit per endpoint
  typedef struct packed {
    logic [NUM_EP-1:0] stallClr;
    logic [NUM_EP-1:0] armClr;
  } strobe_t;
endpackage

// File: rtl/ep_regfile.sv
module ep_regfile
  import usbep_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [WORD_W-1:0]    busWdata,
  output logic [WORD_W-1:0]    busRdata,
  input  logic                 sofValid,
  input  logic [FRAME_W-1:0]   sofFrame,
  input  strobe_t              strobe,
  output ctrl_t [NUM_EP-1:0]   epWords,
  output logic [DEVADDR_W-1:0] devAddr,
  output logic                 cmdDoneValid,
  output logic                 cmdDoneErr
);
  logic wrEn;
  logic [NUM_EP-1:0] wrHit;
  logic [FRAME_W-1:0] frameReg;
  logic [DEVADDR_W-1:0] addrReg;
  logic cmdHit;
  logic unusedWdata;

  assign wrEn   = busSel && busWr;
  assign cmdHit = wrEn && (busAddr == BUS_AW'(A_CMD));
  assign unusedWdata = ^busWdata[WORD_W-1:DEVADDR_W];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    localparam logic [BUS_AW-1:0] EP_ADDR = BUS_AW'(A_EP_BASE + e);
    assign wrHit[e] = wrEn && (busAddr == EP_ADDR);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        epWords[e] <= '0;
      end else if (wrHit[e]) begin
        epWords[e] <= busWdata[CTRL_W-1:0];
      end else begin
        if (strobe.stallClr[e]) epWords[e][B_STL] <= 1'b0;
        if (strobe.armClr[e])   epWords[e][B_ARM] <= 1'b0;
      end
    end

    p_write_wins_r13: assert property (@(posedge clk) disable iff (!rstN)
      wrHit[e] |=> epWords[e] == $past(busWdata[CTRL_W-1:0]));
    p_stall_one_shot_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.stallClr[e] && !wrHit[e]) |=> !epWords[e][B_STL]);
    p_arm_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.armClr[e] && !wrHit[e]) |=> !epWords[e][B_ARM]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg     <= '0;
      addrReg      <= '0;
      cmdDoneValid <= 1'b0;
      cmdDoneErr   <= 1'b0;
    end else begin
      if (sofValid) frameReg <= sofFrame;
      if (wrEn && busAddr == BUS_AW'(A_DEVADDR)) addrReg <= busWdata[DEVADDR_W-1:0];
      cmdDoneValid <= cmdHit;
      if (cmdHit) cmdDoneErr <= busWdata[0];
    end
  end

  assign devAddr = addrReg;

  always_comb begin
    busRdata = '0;
    if (busAddr == BUS_AW'(A_FRAME))   busRdata = WORD_W'(frameReg);
    if (busAddr == BUS_AW'(A_DEVADDR)) busRdata = WORD_W'(addrReg);
    for (int i = 0; i < NUM_EP; i++) begin
      if (busAddr == BUS_AW'(A_EP_BASE + i)) busRdata = WORD_W'(epWords[i]);
    end
  end

  p_frame_latch_r10: assert property (@(posedge clk) disable iff (!rstN)
    sofValid |=> frameReg == $past(sofFrame));
  p_cmd_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdHit |=> cmdDoneValid && (cmdDoneErr == $past(busWdata[0])));
  p_cmd_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cmdHit |=> !cmdDoneValid);
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
  import usbep_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tokValid,
  input  logic [EP_IDX_W-1:0] tokEp,
  input  logic                tokIn,
  input  logic                doneValid,
  input  logic [EP_IDX_W-1:0] doneEp,
  input  ctrl_t [NUM_EP-1:0]  epWords,
  output strobe_t             strobe,
  output logic                hsValid,
  output hs_e                 hsCode,
  output logic [EP_IDX_W-1:0] hsEp
);
  ctrl_t cur;
  hs_e   decide;

  assign cur = epWords[tokEp];

  always_comb begin
    decide = HS_IGNORE;
    if (!cur[B_EN] || (cur[B_DIR] != tokIn)) begin
      decide = HS_IGNORE;
    end else if (cur[B_ISO]) begin
      if (cur[B_ARM]) decide = cur[B_ZLP] ? HS_ZLP : HS_PROCEED;
      else            decide = HS_IGNORE;
    end else if (cur[B_STL]) begin
      decide = HS_STALL;
    end else if (!cur[B_ARM]) begin
      decide = HS_NAK;
    end else begin
      decide = cur[B_ZLP] ? HS_ZLP : HS_PROCEED;
    end
  end

  always_comb begin
    strobe.stallClr = '0;
    strobe.armClr   = '0;
    if (tokValid && decide == HS_STALL) strobe.stallClr = NUM_EP'(1) << tokEp;
    if (doneValid) strobe.armClr = NUM_EP'(1) << doneEp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsValid <= 1'b0;
      hsCode  <= HS_IGNORE;
      hsEp    <= '0;
    end else begin
      hsValid <= tokValid;
      hsCode  <= tokValid ? decide : HS_IGNORE;
      hsEp    <= tokEp;
    end
  end

  p_reply_timing_r3: assert property (@(posedge clk) disable iff (!rstN)
    tokValid |=> hsValid && hsEp == $past(tokEp));
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tokValid |=> !hsValid);
  p_disabled_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && !cur[B_EN]) |=> hsCode == HS_IGNORE);
  p_unarmed_nak_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && cur[B_EN] && cur[B_DIR] == tokIn && !cur[B_ISO] && !cur[B_STL] && !cur[B_ARM])
      |=> hsCode == HS_NAK);
  p_dir_mismatch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && cur[B_DIR] != tokIn) |=> hsCode == HS_IGNORE);
  p_iso_no_nak_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && cur[B_ISO]) |=> (hsCode != HS_NAK && hsCode != HS_STALL));
endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usbep_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [WORD_W-1:0]    busWdata,
  output logic [WORD_W-1:0]    busRdata,
  input  logic                 sofValid,
  input  logic [FRAME_W-1:0]   sofFrame,
  input  logic                 tokValid,
  input  logic [EP_IDX_W-1:0]  tokEp,
  input  logic                 tokIn,
  input  logic                 doneValid,
  input  logic [EP_IDX_W-1:0]  doneEp,
  output logic                 hsValid,
  output logic [2:0]           hsCode,
  output logic [EP_IDX_W-1:0]  hsEp,
  output logic [DEVADDR_W-1:0] devAddr,
  output logic                 cmdDoneValid,
  output logic                 cmdDoneErr
);
  strobe_t            strobe;
  ctrl_t [NUM_EP-1:0] epWords;
  hs_e                hsCodeE;

  ep_regfile u_regs (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .sofValid(sofValid), .sofFrame(sofFrame),
    .strobe(strobe), .epWords(epWords), .devAddr(devAddr),
    .cmdDoneValid(cmdDoneValid), .cmdDoneErr(cmdDoneErr)
  );

  ep_hs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .tokValid(tokValid), .tokEp(tokEp), .tokIn(tokIn),
    .doneValid(doneValid), .doneEp(doneEp),
    .epWords(epWords), .strobe(strobe),
    .hsValid(hsValid), .hsCode(hsCodeE), .hsEp(hsEp)
  );

  assign hsCode = hsCodeE;
endmodule

// File: tb/tb_usb_ep_ctrl.sv
module tb_usb_ep_ctrl;
  localparam int C_IGN = 0, C_NAK = 1, C_STL = 2, C_ZLP = 3, C_PRO = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busWr = 0;
  logic [3:0] busAddr = 0;
  logic [15:0] busWdata = 0;
  logic [15:0] busRdata;
  logic sofValid = 0;
  logic [10:0] sofFrame = 0;
  logic tokValid = 0, tokIn = 0, doneValid = 0;
  logic [1:0] tokEp = 0, doneEp = 0;
  logic hsValid, cmdDoneValid, cmdDoneErr;
  logic [2:0] hsCode;
  logic [1:0] hsEp;
  logic [6:0] devAddr;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  typedef struct { int code; int ep; string tag; } exp_t;
  exp_t expQ[$];
  exp_t monItem;
  logic [5:0] mdl [4];

  always #5 clk = ~clk;

  usb_ep_ctrl dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sofValid(sofValid), .sofFrame(sofFrame),
    .tokValid(tokValid), .tokEp(tokEp), .tokIn(tokIn), .doneValid(doneValid),
    .doneEp(doneEp), .hsValid(hsValid), .hsCode(hsCode), .hsEp(hsEp),
    .devAddr(devAddr), .cmdDoneValid(cmdDoneValid), .cmdDoneErr(cmdDoneErr)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model(int ep, bit inDir);
    logic [5:0] w = mdl[ep];
    if (!w[0] || w[3] != inDir) return C_IGN;
    if (w[4]) return w[1] ? (w[5] ? C_ZLP : C_PRO) : C_IGN;
    if (w[2]) return C_STL;
    if (!w[1]) return C_NAK;
    return w[5] ? C_ZLP : C_PRO;
  endfunction

  // all tasks start and end at a falling edge
  task automatic wrReg(int a, int d);
    busSel = 1; busWr = 1; busAddr = 4'(a); busWdata = 16'(d);
    if (a >= 4) mdl[a-4] = 6'(d);
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rdReg(int a, int exp, string tag);
    busAddr = 4'(a);
    #1;
    check(busRdata == 16'(exp), tag, busRdata, exp);
    @(negedge clk);
  endtask

  task automatic sendTok(int ep, bit inDir, string tag);
    exp_t e;
    e.code = model(ep, inDir); e.ep = ep; e.tag = tag;
    expQ.push_back(e);
    if (e.code == C_STL) mdl[ep][2] = 1'b0;
    tokValid = 1; tokEp = 2'(ep); tokIn = inDir;
    @(negedge clk);
    tokValid = 0;
  endtask

  task automatic doDone(int ep);
    doneValid = 1; doneEp = 2'(ep); mdl[ep][1] = 1'b0;
    @(negedge clk);
    doneValid = 0;
  endtask

  // scoreboard monitor: every reply is matched against the queue
  always @(negedge clk) begin
    if (rstN && hsValid) begin
      if (expQ.size() == 0) begin
        check(0, "R3 unexpected reply", hsCode, -1);
      end else begin
        monItem = expQ.pop_front();
        check(hsCode == 3'(monItem.code), monItem.tag, hsCode, monItem.code);
        check(hsEp == 2'(monItem.ep), "R3 hsEp", hsEp, monItem.ep);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check(hsValid == 0, "R1 hsValid", hsValid, 0);
    for (int i = 0; i < 4; i++) rdReg(4 + i, 0, "R1 endpoint word");
    rdReg(1, 0, "R1 address");
    rdReg(0, 0, "R1 frame");
    // R2 map and reserved bits
    wrReg(5, 16'hFFFF);
    rdReg(5, 16'h003F, "R2 endpoint reserved bits");
    wrReg(0, 16'h0123);
    rdReg(0, 0, "R2 frame read-only");
    rdReg(2, 0, "R2 command reads zero");
    // R4 disabled
    wrReg(5, 16'h0000);
    sendTok(1, 1, "R4 disabled ignore");
    wrReg(6, 16'h003E);
    sendTok(2, 1, "R4 disabled with other bits ignore");
    // R5 NAK
    wrReg(5, 16'h0009);
    sendTok(1, 1, "R5 unarmed NAK");
    check(hsValid == 1, "R3 reply one cycle after token", hsValid, 1);
    @(negedge clk);
    check(hsValid == 0, "R3 no reply without token", hsValid, 0);
    // R6 stall priority and one-shot
    wrReg(5, 16'h000F);
    sendTok(1, 1, "R6 stall over arm");
    rdReg(5, 16'h000B, "R6 stall cleared");
    sendTok(1, 1, "R6 proceed after stall");
    // R7 done clears arm, zero length
    doDone(1);
    rdReg(5, 16'h0009, "R7 arm cleared by done");
    sendTok(1, 1, "R7 NAK after done");
    wrReg(6, 16'h0023);
    sendTok(2, 0, "R7 zero length OUT");
    wrReg(4, 16'h0003);
    sendTok(0, 0, "R7 proceed OUT");
    // R8 direction mismatch
    wrReg(7, 16'h000F);
    sendTok(3, 0, "R8 mismatch ignore");
    rdReg(7, 16'h000F, "R8 arm and stall kept");
    // R9 isochronous
    wrReg(7, 16'h001D);
    sendTok(3, 1, "R9 iso unarmed ignore");
    wrReg(7, 16'h001F);
    sendTok(3, 1, "R9 iso armed proceed despite stall");
    rdReg(7, 16'h001F, "R9 iso stall kept");
    wrReg(7, 16'h003F);
    sendTok(3, 1, "R9 iso zero length");
    // R10 start-of-frame
    sofValid = 1; sofFrame = 11'h5A5; @(negedge clk); sofValid = 0;
    rdReg(0, 16'h05A5, "R10 frame latch");
    sofValid = 1; sofFrame = 11'h7FF; @(negedge clk); sofValid = 0;
    rdReg(0, 16'h07FF, "R10 frame upper zero");
    // R11 address
    wrReg(1, 16'hFFFF);
    rdReg(1, 16'h007F, "R11 address width");
    check(devAddr == 7'h7F, "R11 devAddr", devAddr, 7'h7F);
    wrReg(1, 16'h0005);
    check(devAddr == 7'h05, "R11 devAddr update", devAddr, 5);
    // R12 command done
    wrReg(2, 16'h0000);
    check(cmdDoneValid && !cmdDoneErr, "R12 success pulse", {cmdDoneValid, cmdDoneErr}, 2);
    @(negedge clk);
    check(!cmdDoneValid, "R12 single cycle", cmdDoneValid, 0);
    wrReg(2, 16'h0001);
    check(cmdDoneValid && cmdDoneErr, "R12 error pulse", {cmdDoneValid, cmdDoneErr}, 3);
    // R13 write wins over hardware clear
    wrReg(4, 16'h0001);
    busSel = 1; busWr = 1; busAddr = 4'd4; busWdata = 16'h0003;
    doneValid = 1; doneEp = 2'd0; mdl[0] = 6'h03;
    @(negedge clk);
    busSel = 0; busWr = 0; doneValid = 0;
    rdReg(4, 16'h0003, "R13 write kept over done");
    sendTok(0, 0, "R13 proceed after collision");
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all replies seen", expQ.size(), 0);
    finish();
  end
endmodule